// File: doc/BRIEF.md
# Serial configuration register bank with switchable bit order

This block is a serial-port slave that gives a host access to a small bank of 8-bit configuration registers. The interface has an active-low select (`cs_n`) and a serial clock (`sclk`). The single bidirectional data wire is split into a data input, a data output and an output-enable that the pad ring combines. Each access opens with one instruction byte. That byte holds a read/write flag, a byte count and a start address. Between one and four data bytes follow, and the address steps up by one after each byte. The stored register values are also driven out in parallel on `ctrl_o`, so the rest of the chip can use them as static control.

Register 0 controls the port itself. Bit 6 selects LSB-first shifting and bit 5 requests a software reset. The design counts rising `sclk` edges from the moment `cs_n` goes low, and a byte completes on every eighth edge. A write byte lands in its register on that same edge, so in a burst the registers change one after another rather than all together. Raising `cs_n` at any point abandons the access and drops any partial byte. Address 0xF returns a fixed revision code, and bit 7 of register 4 reflects a live status input.

Top module: `cfg_spi_regbank`

## Requirements
- R1: While `rst_n` is low, every register returns to its default: 0x9F at 2, 0x02 at 3, 0x01 at 4, 0x80 at 5 and 0x00 at 0, 1, 6, 7 and 8. This also restores MSB-first order and clears any transfer in progress.
- R2: In MSB-first order the instruction byte is shifted as R/W (1 = read), then count-1 in two bits, then a 5-bit address, highest bit first. Data bytes are shifted bit 7 first.
- R3: With register 0 bit 6 set, every byte is shifted bit 0 first. The instruction then carries the address bits first, then the count bits, and R/W last.
- R4: An instruction with count field c transfers c+1 data bytes to consecutive addresses. Each write byte is committed on its own 8th rising edge, so a burst cut short in byte 2 keeps byte 1.
- R5: Raising `cs_n` before the 8th bit of a byte discards that byte. No register changes while `cs_n` is high.
- R6: Data bytes clocked beyond the instruction's count are ignored. They neither write a register nor enable the output.
- R7: Writing register 0 with bit 5 set returns registers 1 to 8 to their defaults. Register 0 keeps the written value with bit 5 cleared.
- R8: Address 0xF reads 0x03 and ignores writes. Bit 7 of register 4 reads the `status_in` pin, is not stored, and shows as 0 on `ctrl_o`.
- R9: `sdo_oe` is high only during the data bytes of a read, never during the instruction byte or while `cs_n` is high. `sdo` changes on falling `sclk` edges.
- R10: Addresses 9 to 14 and 16 to 31 read 0x00 and ignore writes.
- R11: `ctrl_o[8*i+7:8*i]` always equals the stored value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sclk | input | 1 | Serial clock; input is sampled on rising edges |
| cs_n | input | 1 | Transfer select, active low; high aborts |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data, launched on falling edges |
| sdo_oe | output | 1 | Output enable for the shared data wire |
| status_in | input | 1 | Live status reported in register 4 bit 7 |
| ctrl_o | output | 72 | Parallel image of registers 0 to 8 |

## Verification
The assertions are clocked on rising `sclk` edges. They assume `cs_n` is held high while `rst_n` is low, and that `cs_n` and `sdi` change only near falling edges, never close to a rising edge. The bench keeps within these assumptions by running `sclk` freely and driving every host signal just after a falling edge. It samples `sdo` and `sdo_oe` a few nanoseconds after that same falling edge, once the read bit has settled.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CW = $clog2(BYTE_W);
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic {PH_INSTR, PH_DATA} phase_e;

   function automatic byte_t reg_default(input int idx);
      case (idx)
         2:       return 8'h9F;
         3:       return 8'h02;
         4:       return 8'h01;
         5:       return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   function automatic byte_t write_mask(input int idx, input int status_reg,
                                        input int status_bit, input int swr_bit);
      byte_t m;
      m = '1;
      if (idx == status_reg) m[status_bit] = 1'b0;
      if (idx == 0)          m[swr_bit]    = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter
   import cfg_spi_pkg::*;
(
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              lsb_first,
   output byte_t             byte_next,
   output logic              byte_done,
   output logic [BIT_CW-1:0] bit_cnt
);
   byte_t sr_q;

   always_comb begin
      if (lsb_first) byte_next = {sdi, sr_q[BYTE_W-1:1]};
      else           byte_next = {sr_q[BYTE_W-2:0], sdi};
   end

   assign byte_done = !cs_n && (bit_cnt == BIT_CW'(BYTE_W-1));

   always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sr_q    <= '0;
      end else if (cs_n) begin
         bit_cnt <= '0;
         sr_q    <= '0;
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
         sr_q    <= byte_next;
      end
   end
endmodule

// File: rtl/cfg_spi_ctrl.sv
module cfg_spi_ctrl
   import cfg_spi_pkg::*;
#(
   parameter int CNT_W = 2,
   parameter int AW    = 5
)(
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              lsb_first,
   input  byte_t             byte_next,
   input  logic              byte_done,
   input  logic [BIT_CW-1:0] bit_cnt,
   input  byte_t             rd_data,
   output logic              wr_en,
   output logic [AW-1:0]     addr,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int LEFT_W = CNT_W + 1;

   phase_e            phase_q;
   logic              rd_q;
   logic [LEFT_W-1:0] left_q;
   logic              more;

   assign more  = (left_q != '0);
   assign wr_en = byte_done && (phase_q == PH_DATA) && !rd_q && more;

   always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_INSTR;
         rd_q    <= 1'b0;
         left_q  <= '0;
         addr    <= '0;
      end else if (cs_n) begin
         phase_q <= PH_INSTR;
         rd_q    <= 1'b0;
         left_q  <= '0;
      end else if (byte_done) begin
         if (phase_q == PH_INSTR) begin
            rd_q    <= byte_next[BYTE_W-1];
            left_q  <= LEFT_W'(byte_next[BYTE_W-2 -: CNT_W]) + 1'b1;
            addr    <= byte_next[AW-1:0];
            phase_q <= PH_DATA;
         end else if (more) begin
            addr   <= addr + 1'b1;
            left_q <= left_q - 1'b1;
         end
      end
   end

   always_ff @(negedge sclk or posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (cs_n) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else begin
         sdo_oe <= (phase_q == PH_DATA) && rd_q && more;
         sdo    <= lsb_first ? rd_data[bit_cnt]
                             : rd_data[BIT_CW'(BYTE_W-1) - bit_cnt];
      end
   end
endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
   import cfg_spi_pkg::*;
#(
   parameter int          NREG       = 9,
   parameter int          AW         = 5,
   parameter logic [3:0]  REV        = 4'h3,
   parameter int          REV_ADDR   = 15,
   parameter int          STATUS_REG = 4,
   parameter int          STATUS_BIT = 7,
   parameter int          SWR_BIT    = 5
)(
   input  logic                   sclk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          addr,
   input  byte_t                  wr_data,
   input  logic                   status_in,
   output byte_t                  rd_data,
   output logic [NREG*BYTE_W-1:0] ctrl_o
);
   logic swr;
   assign swr = wr_en && (addr == '0) && wr_data[SWR_BIT];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam byte_t DEF  = reg_default(i);
      localparam byte_t MASK = write_mask(i, STATUS_REG, STATUS_BIT, SWR_BIT);
      byte_t q;
      if (i == 0) begin : g_port
         always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)                       q <= DEF;
            else if (wr_en && addr == AW'(i)) q <= wr_data & MASK;
         end
      end else begin : g_cfg
         always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)                       q <= DEF;
            else if (swr)                     q <= DEF;
            else if (wr_en && addr == AW'(i)) q <= wr_data & MASK;
         end
      end
      assign ctrl_o[i*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = '0;
      if (addr == AW'(REV_ADDR)) begin
         rd_data = {{(BYTE_W-4){1'b0}}, REV};
      end else if (int'(addr) < NREG) begin
         rd_data = ctrl_o[int'(addr)*BYTE_W +: BYTE_W];
         if (addr == AW'(STATUS_REG)) rd_data[STATUS_BIT] = status_in;
      end
   end
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
   import cfg_spi_pkg::*;
#(
   parameter int          NREG       = 9,
   parameter int          CNT_W      = 2,
   parameter logic [3:0]  REV        = 4'h3,
   parameter int          REV_ADDR   = 15,
   parameter int          STATUS_REG = 4,
   parameter int          STATUS_BIT = 7,
   parameter int          LSB_BIT    = 6,
   parameter int          SWR_BIT    = 5
)(
   input  logic                   rst_n,
   input  logic                   sclk,
   input  logic                   cs_n,
   input  logic                   sdi,
   output logic                   sdo,
   output logic                   sdo_oe,
   input  logic                   status_in,
   output logic [NREG*BYTE_W-1:0] ctrl_o
);
   localparam int AW = BYTE_W - 1 - CNT_W;

   if (REV_ADDR >= (1 << AW) || NREG > REV_ADDR) begin : g_bad_map
      $error("register map does not fit the address field");
   end
   if (STATUS_REG >= NREG || STATUS_BIT >= BYTE_W) begin : g_bad_status
      $error("status bit outside the register bank");
   end
   if (LSB_BIT == SWR_BIT || LSB_BIT >= BYTE_W || SWR_BIT >= BYTE_W) begin : g_bad_port
      $error("port control bits overlap or exceed a byte");
   end

   logic              lsb_first;
   byte_t             byte_next;
   logic              byte_done;
   logic [BIT_CW-1:0] bit_cnt;
   byte_t             rd_data;
   logic              wr_en;
   logic [AW-1:0]     addr;

   assign lsb_first = ctrl_o[LSB_BIT];

   cfg_spi_shifter u_shift (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
      .lsb_first(lsb_first), .byte_next(byte_next),
      .byte_done(byte_done), .bit_cnt(bit_cnt)
   );

   cfg_spi_ctrl #(.CNT_W(CNT_W), .AW(AW)) u_ctrl (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .lsb_first(lsb_first),
      .byte_next(byte_next), .byte_done(byte_done), .bit_cnt(bit_cnt),
      .rd_data(rd_data), .wr_en(wr_en), .addr(addr),
      .sdo(sdo), .sdo_oe(sdo_oe)
   );

   cfg_spi_regfile #(
      .NREG(NREG), .AW(AW), .REV(REV), .REV_ADDR(REV_ADDR),
      .STATUS_REG(STATUS_REG), .STATUS_BIT(STATUS_BIT), .SWR_BIT(SWR_BIT)
   ) u_regs (
      .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(byte_next), .status_in(status_in),
      .rd_data(rd_data), .ctrl_o(ctrl_o)
   );
endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk #(
   parameter int NREG       = 9,
   parameter int STATUS_REG = 4,
   parameter int STATUS_BIT = 7,
   parameter int SWR_BIT    = 5
)(
   input logic              sclk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sdo_oe,
   input logic [NREG*8-1:0] ctrl_o
);
   a_r9_oe_needs_select: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |-> !sdo_oe);

   a_r9_no_oe_in_instruction: assert property (@(posedge sclk) disable iff (!rst_n)
      $fell(cs_n) |=> !sdo_oe);

   a_r5_hold_while_idle: assert property (@(posedge sclk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> $stable(ctrl_o));

   a_r8_status_not_stored: assert property (@(posedge sclk) disable iff (!rst_n)
      !ctrl_o[STATUS_REG*8 + STATUS_BIT]);

   a_r7_swr_bit_clears: assert property (@(posedge sclk) disable iff (!rst_n)
      !ctrl_o[SWR_BIT]);
endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk #(
   .NREG(NREG), .STATUS_REG(STATUS_REG), .STATUS_BIT(STATUS_BIT), .SWR_BIT(SWR_BIT)
) u_chk (
   .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .ctrl_o(ctrl_o)
);

// File: tb/cfg_spi_regbank_bench.sv
module cfg_spi_regbank_bench;
   logic        rst_n = 1'b0;
   logic        sclk  = 1'b0;
   logic        cs_n  = 1'b1;
   logic        sdi   = 1'b0;
   logic        status_in = 1'b0;
   logic        sdo, sdo_oe;
   logic [71:0] ctrl_o;

   int checks = 0;
   int errors = 0;
   bit lsb = 1'b0;
   logic [7:0] exp_r [0:8];
   logic [7:0] tx [0:7];
   logic [7:0] rx [0:7];
   int oe_instr, oe_data;

   always #5 sclk = ~sclk;

   cfg_spi_regbank u_cfg_spi_regbank (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .ctrl_o(ctrl_o)
   );

   function automatic logic [7:0] dflt(input int i);
      case (i)
         2: return 8'h9F;  3: return 8'h02;
         4: return 8'h01;  5: return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] model_read(input int a);
      if (a == 15) return 8'h03;
      if (a < 9)   return (a == 4) ? (exp_r[4] | {status_in, 7'b0}) : exp_r[a];
      return 8'h00;
   endfunction

   task automatic model_write(input int a, input logic [7:0] v);
      if (a == 0) begin
         if (v[5]) for (int i = 1; i < 9; i++) exp_r[i] = dflt(i);
         exp_r[0] = v & 8'hDF;
      end else if (a < 9) begin
         exp_r[a] = (a == 4) ? (v & 8'h7F) : v;
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 9; i++) exp_r[i] = dflt(i);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic check_ctrl(input string req);
      for (int i = 0; i < 9; i++) check(req, 32'(ctrl_o[i*8 +: 8]), 32'(exp_r[i]));
   endtask

   // nsend: full data bytes clocked, extra: further bits of one more byte
   task automatic xfer(input bit rd, input int cnt, input int a, input int nsend, input int extra);
      logic [7:0] ins, v;
      int total;
      ins = {rd, 2'(cnt - 1), 5'(a)};
      total = 8 + 8*nsend + extra;
      oe_instr = 0; oe_data = 0;
      for (int b = 0; b < total; b++) begin
         int j = b / 8;
         int k = b % 8;
         int idx = lsb ? k : 7 - k;
         v = (j == 0) ? ins : tx[j-1];
         @(negedge sclk);
         cs_n = 1'b0;
         sdi  = v[idx];
         #3;
         if (j == 0) begin
            if (sdo_oe) oe_instr++;
         end else begin
            if (sdo_oe) oe_data++;
            rx[j-1][idx] = sdo;
         end
      end
      @(negedge sclk);
      cs_n = 1'b1;
      sdi  = 1'b0;
      @(negedge sclk);
   endtask

   task automatic wr1(input int a, input logic [7:0] v);
      tx[0] = v;
      xfer(1'b0, 1, a, 1, 0);
      model_write(a, v);
   endtask

   task automatic rd_check(input string req, input int a, input int cnt);
      xfer(1'b1, cnt, a, cnt, 0);
      for (int j = 0; j < cnt; j++) check(req, 32'(rx[j]), 32'(model_read((a + j) % 32)));
      check({req, " oe"}, 32'(oe_instr * 100 + oe_data), 32'(8 * cnt));
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      model_reset();
      repeat (4) @(negedge sclk);
      // R1: defaults while and after reset
      check_ctrl("R1 reset value");
      check("R1 oe at reset", 32'(sdo_oe), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge sclk);

      // R2, R11: MSB-first sweep of registers 1..8
      for (int a = 1; a < 9; a++) begin
         wr1(a, 8'((a * 37 + 5)));
         check_ctrl("R11 parallel image");
         rd_check("R2 msb read", a, 1);
      end

      // R8: status bit and revision
      status_in = 1'b1;
      wr1(4, 8'hFF);
      check_ctrl("R8 status not stored");
      rd_check("R8 status live", 4, 1);
      status_in = 1'b0;
      rd_check("R8 status low", 4, 1);
      rd_check("R8 revision", 15, 1);
      wr1(15, 8'hAA);
      rd_check("R8 revision after write", 15, 1);
      check_ctrl("R8 revision write ignored");

      // R10: unmapped addresses
      wr1(10, 8'h55);
      wr1(20, 8'h66);
      check_ctrl("R10 unmapped write");
      rd_check("R10 unmapped read a", 10, 1);
      rd_check("R10 unmapped read b", 25, 1);

      // R4: bursts
      tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
      xfer(1'b0, 4, 5, 4, 0);
      for (int j = 0; j < 4; j++) model_write(5 + j, tx[j]);
      check_ctrl("R4 burst write");
      rd_check("R4 burst read", 1, 4);
      rd_check("R4 burst read wrap", 7, 4);

      // R5: abort part-way through a byte
      tx[0] = 8'hC3;
      xfer(1'b0, 1, 3, 0, 5);
      check_ctrl("R5 partial byte dropped");

      // R4: burst cut inside byte 2 keeps byte 1
      tx[0] = 8'hA1; tx[1] = 8'hB2;
      xfer(1'b0, 2, 6, 1, 3);
      model_write(6, 8'hA1);
      check_ctrl("R4 per-byte commit");

      // R6: bytes past the count
      tx[0] = 8'h5A; tx[1] = 8'hE7;
      xfer(1'b0, 1, 1, 2, 0);
      model_write(1, 8'h5A);
      check_ctrl("R6 extra write byte");
      xfer(1'b1, 1, 2, 2, 0);
      check("R6 extra read byte oe", 32'(oe_data), 8);
      check("R6 first read byte", 32'(rx[0]), 32'(model_read(2)));

      // R3: switch to LSB-first and sweep again
      wr1(0, 8'h40);
      lsb = 1'b1;
      check_ctrl("R3 mode register");
      for (int a = 1; a < 9; a++) begin
         wr1(a, 8'((a * 91 + 17)));
         check_ctrl("R3 lsb write");
         rd_check("R3 lsb read", a, 1);
      end
      tx[0] = 8'h0F; tx[1] = 8'hF0; tx[2] = 8'h3C;
      xfer(1'b0, 3, 2, 3, 0);
      for (int j = 0; j < 3; j++) model_write(2 + j, tx[j]);
      check_ctrl("R3 lsb burst");
      rd_check("R3 lsb burst read", 0, 4);

      // R7: software reset keeps register 0 minus its reset bit
      wr1(0, 8'h60);
      check_ctrl("R7 soft reset");
      rd_check("R7 still lsb", 2, 2);

      // R1: hardware reset restores MSB-first and defaults
      @(negedge sclk);
      rst_n = 1'b0;
      repeat (2) @(negedge sclk);
      model_reset();
      check_ctrl("R1 hard reset");
      rst_n = 1'b1;
      lsb = 1'b0;
      @(negedge sclk);
      rd_check("R1 msb after reset", 2, 4);

      report();
   end
endmodule